// File: doc/BRIEF.md
# Fractional-Period Precision Time Counter

This block keeps a free-running time of day as a 48-bit seconds count and a 30-bit nanoseconds count. On every reference clock cycle it advances by a programmable period. The period is a whole number of nanoseconds plus a fraction, given as a numerator over a denominator. A fraction accumulator decides in which cycles one extra nanosecond is added, so the long-run rate matches the programmed period. A frequency servo elsewhere tunes the rate by rewriting the numerator.

Software reaches the block through a simple word-addressed register port. It loads period values and target time values into staging registers. Nothing happens to the running clock until a write to the command register. That command can commit a new period, load an absolute time, or apply a signed nanosecond step. A read of the live seconds-low word captures the seconds-high and nanoseconds words at the same instant, so a three-word read always gives one coherent time.

Top module: `ptp_frac_clock`

## Requirements
- R1: After reset the time is zero. The period registers read back whole = 2 (address 0), numerator = 0 (address 1) and denominator = 100000000 (address 2). The captured seconds-high (address 8) and nanoseconds (address 10) words read zero.
- R2: Once a period is committed, each cycle adds the whole part plus one extra nanosecond whenever the fraction accumulator reaches the denominator. Over G cycles after the commit the time therefore advances by G*whole + floor(G*numerator/denominator).
- R3: A denominator of zero, or a numerator not below the denominator, switches the fraction off. The advance is then exactly whole nanoseconds per cycle.
- R4: Writes to the period registers (addresses 0, 1, 2) have no effect until a command write to address 6 with bit 2 set. That commit also restarts the fraction accumulator from zero.
- R5: When the nanoseconds count reaches 1000000000 it wraps, and the excess carries into the seconds count. The carry propagates through all 48 bits, including the upper 16 (seconds-high).
- R6: A command write with bit 0 set loads the staged time at that edge, with no increment added. The staged time is seconds-high at address 3 (16 bits), seconds-low at address 4, and nanoseconds at address 5, bits 29:0. A staged nanoseconds value of 1000000000 or more loads as that value minus 1000000000, with one second added.
- R7: A command write with bit 1 set applies a step. The magnitude is address 5 bits 29:0; it is subtracted when address 5 bit 31 is set and added otherwise. The step is combined with that cycle's increment. The result may carry or borrow up to two seconds.
- R8: A command with both bit 0 and bit 1 set performs only the absolute load. The step is dropped.
- R9: Read data appears one cycle after the read request. A read of address 9 returns the live seconds-low word and captures seconds-high and nanoseconds. Reads of addresses 8 and 10 return those captured values, not the live ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the time advances once per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write request |
| addr | input | 4 | Word address for a write or read |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rdata | output | 32 | Read data, valid the cycle after rd_en |

## Verification
A period or time command acts on the same clock edge that samples the command write. The fraction accumulator restarts on that edge, and every later edge adds one increment. A read request is registered on its edge. It returns the state held just before that edge, and the data is sampled at the following falling edge. The bench counts the edges between each command and the seconds-low read, and predicts the time from that count. The seconds-high and nanoseconds words are read later. They must equal the captured values, not the time that has moved on since.

// File: rtl/ptp_frac_pkg.sv
package ptp_frac_pkg;

  localparam int ADDR_W = 4;

  // word addresses of the register port
  localparam logic [ADDR_W-1:0] A_PER_WHOLE   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PER_NUM     = 4'd1;
  localparam logic [ADDR_W-1:0] A_PER_DEN     = 4'd2;
  localparam logic [ADDR_W-1:0] A_SET_SEC_HI  = 4'd3;
  localparam logic [ADDR_W-1:0] A_SET_SEC_LO  = 4'd4;
  localparam logic [ADDR_W-1:0] A_SET_NS      = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMD         = 4'd6;
  localparam logic [ADDR_W-1:0] A_TIME_SEC_HI = 4'd8;
  localparam logic [ADDR_W-1:0] A_TIME_SEC_LO = 4'd9;
  localparam logic [ADDR_W-1:0] A_TIME_NS     = 4'd10;

  // command word bit positions
  localparam int CMD_LOAD_BIT   = 0;
  localparam int CMD_STEP_BIT   = 1;
  localparam int CMD_PERIOD_BIT = 2;

  typedef struct packed {
    logic period;
    logic step;
    logic load;
  } cmd_t;

endpackage

// File: rtl/ptp_frac_regs.sv
module ptp_frac_regs
  import ptp_frac_pkg::*;
#(
  parameter int SEC_W     = 48,
  parameter int NS_W      = 30,
  parameter int WHOLE_W   = 8,
  parameter int FRAC_W    = 32,
  parameter int BUS_W     = 32,
  parameter int WHOLE_RST = 2,
  parameter int DEN_RST   = 100000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               rd_en,
  input  logic [SEC_W-1:0]   live_sec,
  input  logic [NS_W-1:0]    live_ns,
  output logic [BUS_W-1:0]   rdata,
  output logic [WHOLE_W-1:0] per_whole,
  output logic [FRAC_W-1:0]  per_num,
  output logic [FRAC_W-1:0]  per_den,
  output logic [SEC_W-1:0]   set_sec,
  output logic [NS_W-1:0]    set_ns,
  output logic               set_neg,
  output cmd_t               cmd
);

  localparam int HI_W = SEC_W - BUS_W;

  logic [WHOLE_W-1:0] whole_q;
  logic [FRAC_W-1:0]  num_q, den_q;
  logic [HI_W-1:0]    shi_q;
  logic [BUS_W-1:0]   slo_q;
  logic [NS_W-1:0]    sns_q;
  logic               sneg_q;
  logic [HI_W-1:0]    snap_hi_q;
  logic [NS_W-1:0]    snap_ns_q;
  logic [BUS_W-1:0]   rdata_q, rd_mux;

  logic whole_en, num_en, den_en, shi_en, slo_en, sns_en, snap_en;

  // write decode and command pulses
  always_comb begin
    whole_en   = wr_en && (addr == A_PER_WHOLE);
    num_en     = wr_en && (addr == A_PER_NUM);
    den_en     = wr_en && (addr == A_PER_DEN);
    shi_en     = wr_en && (addr == A_SET_SEC_HI);
    slo_en     = wr_en && (addr == A_SET_SEC_LO);
    sns_en     = wr_en && (addr == A_SET_NS);
    snap_en    = rd_en && (addr == A_TIME_SEC_LO);
    cmd.load   = wr_en && (addr == A_CMD) && wdata[CMD_LOAD_BIT];
    cmd.step   = wr_en && (addr == A_CMD) && wdata[CMD_STEP_BIT];
    cmd.period = wr_en && (addr == A_CMD) && wdata[CMD_PERIOD_BIT];
  end

  // read multiplexer
  always_comb begin
    case (addr)
      A_PER_WHOLE:   rd_mux = BUS_W'(whole_q);
      A_PER_NUM:     rd_mux = BUS_W'(num_q);
      A_PER_DEN:     rd_mux = BUS_W'(den_q);
      A_SET_SEC_HI:  rd_mux = BUS_W'(shi_q);
      A_SET_SEC_LO:  rd_mux = slo_q;
      A_SET_NS:      rd_mux = {sneg_q, (BUS_W-1)'(sns_q)};
      A_TIME_SEC_HI: rd_mux = BUS_W'(snap_hi_q);
      A_TIME_SEC_LO: rd_mux = live_sec[BUS_W-1:0];
      A_TIME_NS:     rd_mux = BUS_W'(snap_ns_q);
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_q <= WHOLE_W'(WHOLE_RST);
      num_q   <= '0;
      den_q   <= FRAC_W'(DEN_RST);
    end else begin
      if (whole_en) whole_q <= wdata[WHOLE_W-1:0];
      if (num_en)   num_q   <= wdata[FRAC_W-1:0];
      if (den_en)   den_q   <= wdata[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shi_q  <= '0;
      slo_q  <= '0;
      sns_q  <= '0;
      sneg_q <= 1'b0;
    end else begin
      if (shi_en) shi_q <= wdata[HI_W-1:0];
      if (slo_en) slo_q <= wdata;
      if (sns_en) begin
        sns_q  <= wdata[NS_W-1:0];
        sneg_q <= wdata[BUS_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_hi_q <= '0;
      snap_ns_q <= '0;
      rdata_q   <= '0;
    end else begin
      if (snap_en) begin
        snap_hi_q <= live_sec[SEC_W-1:BUS_W];
        snap_ns_q <= live_ns;
      end
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign rdata     = rdata_q;
  assign per_whole = whole_q;
  assign per_num   = num_q;
  assign per_den   = den_q;
  assign set_sec   = {shi_q, slo_q};
  assign set_ns    = sns_q;
  assign set_neg   = sneg_q;

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> ($stable(snap_hi_q) && $stable(snap_ns_q))); // R9

endmodule

// File: rtl/ptp_frac_step.sv
module ptp_frac_step #(
  parameter int WHOLE_W   = 8,
  parameter int FRAC_W    = 32,
  parameter int WHOLE_RST = 2,
  parameter int DEN_RST   = 100000000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               period_go,
  input  logic [WHOLE_W-1:0] whole_in,
  input  logic [FRAC_W-1:0]  num_in,
  input  logic [FRAC_W-1:0]  den_in,
  output logic [WHOLE_W:0]   incr
);

  logic [WHOLE_W-1:0] whole_q;
  logic [FRAC_W-1:0]  num_q, den_q, acc_q, acc_d;
  logic [FRAC_W:0]    acc_sum;
  logic               frac_on, carry;

  always_comb begin
    frac_on = (den_q != '0) && (num_q < den_q);
    acc_sum = {1'b0, acc_q} + {1'b0, num_q};
    carry   = frac_on && (acc_sum >= {1'b0, den_q});
    incr    = {1'b0, whole_q} + {{WHOLE_W{1'b0}}, carry};
    if (period_go)
      acc_d = '0;
    else if (!frac_on)
      acc_d = acc_q;
    else if (carry)
      acc_d = FRAC_W'(acc_sum - {1'b0, den_q});
    else
      acc_d = acc_sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whole_q <= WHOLE_W'(WHOLE_RST);
      num_q   <= '0;
      den_q   <= FRAC_W'(DEN_RST);
    end else if (period_go) begin
      whole_q <= whole_in;
      num_q   <= num_in;
      den_q   <= den_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  AST_FRAC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    frac_on |-> (acc_q < den_q)); // R2

  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_go |=> ($stable(whole_q) && $stable(num_q) && $stable(den_q))); // R4

endmodule

// File: rtl/ptp_frac_tod.sv
module ptp_frac_tod #(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int WHOLE_W    = 8,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WHOLE_W:0] incr,
  input  logic             load_go,
  input  logic             step_go,
  input  logic [SEC_W-1:0] set_sec,
  input  logic [NS_W-1:0]  set_ns,
  input  logic             set_neg,
  output logic [SEC_W-1:0] sec,
  output logic [NS_W-1:0]  ns
);

  localparam int VW = NS_W + 3;
  localparam logic signed [VW-1:0] NSPS   = VW'(NS_PER_SEC);
  localparam logic signed [VW-1:0] NSPS2  = NSPS <<< 1;
  localparam logic [NS_W:0]        NSPS_U = (NS_W+1)'(NS_PER_SEC);
  localparam logic [NS_W-1:0]      NS_LIM = NS_W'(NS_PER_SEC);

  logic [SEC_W-1:0]       sec_q, sec_d;
  logic [NS_W-1:0]        ns_q, ns_d, ld_ns;
  logic signed [VW-1:0]   v, v_fix, mag;
  logic signed [2:0]      sec_adj;
  logic                   ld_wrap;

  // running path: increment plus optional step, then normalise
  always_comb begin
    mag = signed'(VW'(set_ns));
    v   = signed'(VW'(ns_q) + VW'(incr));
    if (step_go)
      v = set_neg ? (v - mag) : (v + mag);
    if (v < 0) begin
      if ((v + NSPS) < 0) begin
        v_fix   = v + NSPS2;
        sec_adj = -3'sd2;
      end else begin
        v_fix   = v + NSPS;
        sec_adj = -3'sd1;
      end
    end else if (v >= NSPS2) begin
      v_fix   = v - NSPS2;
      sec_adj = 3'sd2;
    end else if (v >= NSPS) begin
      v_fix   = v - NSPS;
      sec_adj = 3'sd1;
    end else begin
      v_fix   = v;
      sec_adj = 3'sd0;
    end
  end

  // load path: staged value, folded once if not below one second
  always_comb begin
    ld_wrap = {1'b0, set_ns} >= NSPS_U;
    ld_ns   = ld_wrap ? NS_W'({1'b0, set_ns} - NSPS_U) : set_ns;
  end

  always_comb begin
    if (load_go) begin
      ns_d  = ld_ns;
      sec_d = set_sec + SEC_W'(ld_wrap);
    end else begin
      ns_d  = v_fix[NS_W-1:0];
      sec_d = sec_q + SEC_W'(sec_adj);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  assign sec = sec_q;
  assign ns  = ns_q;

  AST_NS_BELOW_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    ns_q < NS_LIM); // R5

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && (set_ns < NS_LIM)) |=> ((ns_q == $past(set_ns)) && (sec_q == $past(set_sec)))); // R6

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_go && step_go && (set_ns < NS_LIM)) |=> (ns_q == $past(set_ns))); // R8

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_go && !step_go) |=>
      (((sec_q == $past(sec_q)) && (ns_q >= $past(ns_q))) ||
       (sec_q == ($past(sec_q) + SEC_W'(1))))); // R2

endmodule

// File: rtl/ptp_frac_clock.sv
module ptp_frac_clock
  import ptp_frac_pkg::*;
#(
  parameter int SEC_W      = 48,
  parameter int NS_W       = 30,
  parameter int WHOLE_W    = 8,
  parameter int FRAC_W     = 32,
  parameter int BUS_W      = 32,
  parameter int WHOLE_RST  = 2,
  parameter int DEN_RST    = 100000000,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rdata
);

  logic               rst_meta_n, rst_sync_n;
  logic [WHOLE_W-1:0] per_whole;
  logic [FRAC_W-1:0]  per_num, per_den;
  logic [SEC_W-1:0]   set_sec, live_sec;
  logic [NS_W-1:0]    set_ns, live_ns;
  logic               set_neg;
  logic [WHOLE_W:0]   incr;
  cmd_t               cmd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  ptp_frac_regs #(
    .SEC_W(SEC_W), .NS_W(NS_W), .WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W),
    .BUS_W(BUS_W), .WHOLE_RST(WHOLE_RST), .DEN_RST(DEN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .live_sec(live_sec), .live_ns(live_ns), .rdata(rdata),
    .per_whole(per_whole), .per_num(per_num), .per_den(per_den),
    .set_sec(set_sec), .set_ns(set_ns), .set_neg(set_neg), .cmd(cmd)
  );

  ptp_frac_step #(
    .WHOLE_W(WHOLE_W), .FRAC_W(FRAC_W), .WHOLE_RST(WHOLE_RST), .DEN_RST(DEN_RST)
  ) u_step (
    .clk(clk), .rst_n(rst_sync_n), .period_go(cmd.period),
    .whole_in(per_whole), .num_in(per_num), .den_in(per_den), .incr(incr)
  );

  ptp_frac_tod #(
    .SEC_W(SEC_W), .NS_W(NS_W), .WHOLE_W(WHOLE_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_tod (
    .clk(clk), .rst_n(rst_sync_n), .incr(incr), .load_go(cmd.load),
    .step_go(cmd.step), .set_sec(set_sec), .set_ns(set_ns), .set_neg(set_neg),
    .sec(live_sec), .ns(live_ns)
  );

endmodule

// File: tb/ptp_frac_clock_test.sv
module ptp_frac_clock_test;

  localparam logic [3:0] A_WHOLE = 4'd0, A_NUM = 4'd1, A_DEN = 4'd2;
  localparam logic [3:0] A_SHI = 4'd3, A_SLO = 4'd4, A_SNS = 4'd5, A_CMD = 4'd6;
  localparam logic [3:0] A_THI = 4'd8, A_TLO = 4'd9, A_TNS = 4'd10;
  localparam longint NSPS = 1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int  n_cmp = 0;
  int  n_err = 0;
  bit  done = 1'b0;
  longint m_sec, m_ns;

  always #5 clk = ~clk;

  ptp_frac_clock uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_norm();
    while (m_ns >= NSPS) begin m_ns -= NSPS; m_sec++; end
    while (m_ns < 0) begin m_ns += NSPS; m_sec--; end
    m_sec &= 64'h0000_FFFF_FFFF_FFFF;
  endtask

  // time captured by the seconds-low read, then the two captured words
  task automatic check_time(input string tag);
    logic [31:0] hi, lo, nsr;
    rd(A_TLO, lo);
    rd(A_THI, hi);
    rd(A_TNS, nsr);
    check({tag, " sec_hi"}, longint'(hi), m_sec >>> 32);
    check({tag, " sec_lo"}, longint'(lo), m_sec & 64'hFFFF_FFFF);
    check({tag, " ns"}, longint'(nsr), m_ns);
  endtask

  // period 2 ns exact; stage time and load it with a period commit
  task automatic setup_time(input logic [15:0] hi, input logic [31:0] lo,
                            input logic [31:0] nsw, input logic [31:0] cmdw);
    wr(A_WHOLE, 32'd2);
    wr(A_NUM, 32'd0);
    wr(A_DEN, 32'd1);
    wr(A_SHI, {16'd0, hi});
    wr(A_SLO, lo);
    wr(A_SNS, nsw);
    wr(A_CMD, cmdw);
  endtask

  task automatic run_period(input string tag, input int whole, input longint num,
                            input longint den, input int g);
    longint expv;
    wr(A_WHOLE, 32'(whole));
    wr(A_NUM, 32'(num));
    wr(A_DEN, 32'(den));
    wr(A_SHI, 32'd0);
    wr(A_SLO, 32'd0);
    wr(A_SNS, 32'd0);
    wr(A_CMD, 32'd5);          // commit period and load zero on one edge
    tick(g);
    expv = longint'(g) * whole;
    if (den != 0 && num < den) expv += (longint'(g) * num) / den;
    m_sec = 0; m_ns = expv; model_norm();
    check_time(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1: reset state
    rd(A_WHOLE, d); check("R1 whole", longint'(d), 2);
    rd(A_NUM, d);   check("R1 num", longint'(d), 0);
    rd(A_DEN, d);   check("R1 den", longint'(d), 100000000);
    rd(A_TNS, d);   check("R1 captured ns", longint'(d), 0);
    rd(A_THI, d);   check("R1 captured sec_hi", longint'(d), 0);
    rd(A_TLO, d);   check("R1 sec_lo", longint'(d), 0);

    // R2 / R3: sweep small denominators, every numerator up to den
    for (int den = 0; den <= 6; den++) begin
      for (int num = 0; num <= den + (den == 0 ? 1 : 0); num++) begin
        for (int whole = 0; whole <= 3; whole++) begin
          if (den == 0 || num >= den)
            run_period("R3 fraction off", whole, num, den, 17 + den);
          else
            run_period("R2 fraction", whole, num, den, 17 + 3 * den);
        end
      end
    end
    // R2: nominal denominator, 2.5 ns and 1.999 ns periods
    run_period("R2 nominal 2.5", 2, 50000000, 100000000, 100);
    run_period("R2 nominal 1.999", 1, 99900000, 100000000, 1000);

    // R4: staged whole written after commit is ignored
    wr(A_WHOLE, 32'd3); wr(A_NUM, 32'd0); wr(A_DEN, 32'd1);
    wr(A_SHI, 32'd0); wr(A_SLO, 32'd0); wr(A_SNS, 32'd0);
    wr(A_CMD, 32'd5);
    wr(A_WHOLE, 32'd7);        // one increment of 3 on this edge
    tick(10);
    m_sec = 0; m_ns = 33; model_norm();
    check_time("R4 uncommitted whole");
    rd(A_WHOLE, d); check("R4 staged readback", longint'(d), 7);

    // R5: nanosecond wrap and 48-bit seconds carry
    setup_time(16'd0, 32'd5, 32'd999999990, 32'd5);
    tick(10);
    m_sec = 5; m_ns = 999999990 + 20; model_norm();
    check_time("R5 wrap");
    setup_time(16'h0012, 32'hFFFF_FFFF, 32'd999999999, 32'd5);
    tick(3);
    m_sec = 64'h0012_FFFF_FFFF; m_ns = 999999999 + 6; model_norm();
    check_time("R5 upper carry");

    // R6: load without increment, and folding of an oversized ns field
    setup_time(16'h0001, 32'd42, 32'd123456, 32'd5);
    m_sec = 64'h0001_0000_002A; m_ns = 123456;
    check_time("R6 exact load");
    setup_time(16'd0, 32'd10, 32'h3FFF_FFFF, 32'd5);
    m_sec = 10; m_ns = 1073741823; model_norm();
    check_time("R6 folded load");

    // R7: steps in both directions, single and double carry or borrow
    setup_time(16'd0, 32'd20, 32'd100, 32'd5);
    wr(A_SNS, 32'd300);
    wr(A_CMD, 32'd2);
    m_sec = 20; m_ns = 100 + 4 + 300; model_norm();
    check_time("R7 positive step");

    setup_time(16'd0, 32'd20, 32'd100, 32'd5);
    wr(A_SNS, 32'h8000_01F4);
    wr(A_CMD, 32'd2);
    m_sec = 20; m_ns = 100 + 4 - 500; model_norm();
    check_time("R7 negative borrow");

    setup_time(16'd0, 32'd3, 32'd100, 32'd5);
    wr(A_SNS, 32'hBFFF_FFFF);
    wr(A_CMD, 32'd2);
    m_sec = 3; m_ns = 100 + 4 - 1073741823; model_norm();
    check_time("R7 double borrow");

    setup_time(16'd0, 32'd3, 32'd999999000, 32'd5);
    wr(A_SNS, 32'h3FFF_FFFF);
    wr(A_CMD, 32'd2);
    m_sec = 3; m_ns = 999999000 + 4 + 1073741823; model_norm();
    check_time("R7 double carry");

    // R8: load and step together, load wins
    setup_time(16'd0, 32'd7, 32'h8000_01F4, 32'd7);
    m_sec = 7; m_ns = 500;
    check_time("R8 load over step");

    // R9: captured words hold while time runs on
    setup_time(16'h0002, 32'd9, 32'd1000, 32'd5);
    rd(A_TLO, d);              // captures state after the load edge
    check("R9 live sec_lo", longint'(d), 9);
    tick(50);
    rd(A_TNS, d);  check("R9 held ns", longint'(d), 1000);
    rd(A_THI, d);  check("R9 held sec_hi", longint'(d), 2);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule